// File: doc/BRIEF.md
# External and Peripheral Interrupt Conditioner

This block collects the interrupt requests of a small processor subsystem into one 16-bit vector. Four external pins arrive asynchronously. Each pin is brought into the system clock domain through a flip-flop synchronizer and then given its fixed polarity. One pin also passes through a glitch filter. Eight internal peripheral request lines come from logic that already runs on the system clock, so they enter without synchronization.

Every source feeds a rising-edge detector. A detected edge sets a pending bit, and that bit stays set until software writes a one to its position on the clear port. The pending vector is gated by a 16-bit enable mask and presented to the processor. A single request line is raised whenever any bit in the gated vector is set. Four positions in the vector are reserved. They can never become pending.

Top module: `irq_cond_mask`

## Requirements
- R1: An external pin passes through two synchronizer flops and one edge register. For a pin without a filter, a change driven between clock edges shows up in the pending vector after the third rising clock edge, and it is not visible after the second.
- R2: Pin 1 is active high and has no filter. A low-to-high transition on it sets pending bit 12.
- R3: Pins 2 and 3 are active low and have no filter. A high-to-low transition sets pending bit 13 (pin 2) or bit 14 (pin 3). A low-to-high transition on either pin sets nothing.
- R4: Pin 0 is active high and filtered. Its synchronized level must hold a new value for DB_CYCLES consecutive clock edges before the filter output follows, so the filter's rising output sets pending bit 1 one edge later. With DB_CYCLES = 4, a pulse lasting DB_CYCLES-1 cycles sets nothing.
- R5: The peripheral inputs 0 to 7 map to pending bits 0, 2, 3, 6, 7, 8, 9 and 11, in that order. The corresponding bit is set by the first clock edge at which the input is high after having been low.
- R6: Pending bits are edge-triggered. A source held high sets its bit only once, and a bit cleared while its source stays high remains clear.
- R7: Writing a one to bit k of the clear port for one cycle clears pending bit k only. If a new edge on that source arrives in the same cycle, the bit stays set.
- R8: Pending bits 4, 5, 10 and 15 always read zero.
- R9: The pending output equals the internal pending state ANDed with the enable mask. With a mask of 0x0081, only the peripheral 0 source (bit 0) and the peripheral 4 source (bit 7) can appear.
- R10: The request output is high exactly when at least one bit of the masked pending output is set.
- R11: After reset, the pending output and the request are zero. With pins 2 and 3 idling high, no bit is set when reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin_i | input | 4 | Asynchronous external interrupt pins, raw levels |
| periph_irq_i | input | 8 | Synchronous peripheral request levels |
| en_mask_i | input | 16 | Per-bit enable mask |
| clr_i | input | 16 | Write-one-to-clear strobe for pending bits |
| irq_pend_o | output | 16 | Masked pending vector |
| irq_req_o | output | 1 | Combined request, any masked pending bit |

## Verification
The assertions assume three things about the inputs. The peripheral request lines are synchronous to the system clock. A clear strobe lasts only as long as software intends. The mask may change in any cycle, because the outputs follow it without delay. The bench changes every input on the falling clock edge, so the synchronous inputs meet the rising edge cleanly. Pins 2 and 3 are held at their idle high level through reset, which keeps the reset-time checks free of spurious edges.

// File: rtl/irq_cond_pkg.sv
package irq_cond_pkg;
   localparam int unsigned VEC_W    = 16;
   localparam int unsigned PIN_N    = 4;
   localparam int unsigned PERIPH_N = 8;

   // Pending-vector position of each external pin and of each peripheral line
   localparam int unsigned PIN_POS    [PIN_N]    = '{1, 12, 13, 14};
   localparam int unsigned PERIPH_POS [PERIPH_N] = '{0, 2, 3, 6, 7, 8, 9, 11};

   // Fixed per-pin conditioning options
   localparam logic [PIN_N-1:0] PIN_ACT_LOW  = 4'b1100;
   localparam logic [PIN_N-1:0] PIN_DEBOUNCE = 4'b0001;

   function automatic logic [VEC_W-1:0] valid_mask();
      logic [VEC_W-1:0] m;
      m = '0;
      for (int i = 0; i < PIN_N; i++)    m[PIN_POS[i]]    = 1'b1;
      for (int i = 0; i < PERIPH_N; i++) m[PERIPH_POS[i]] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= {STAGES{RST_VAL}};
      else        sh_q <= {sh_q[STAGES-2:0], d_i};
   end

   assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/irq_debounce.sv
module irq_debounce #(
   parameter int unsigned DB_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   output logic lvl_o
);
   localparam int unsigned CW = (DB_CYCLES > 2) ? $clog2(DB_CYCLES) : 1;
   localparam logic [CW-1:0] LAST = CW'(DB_CYCLES - 1);

   logic [CW-1:0] cnt_q;
   logic          filt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         filt_q <= 1'b0;
      end else if (lvl_i != filt_q) begin
         if (cnt_q == LAST) begin
            filt_q <= lvl_i;
            cnt_q  <= '0;
         end else begin
            cnt_q  <= cnt_q + 1'b1;
         end
      end else begin
         cnt_q <= '0;
      end
   end

   assign lvl_o = filt_q;
endmodule

// File: rtl/irq_pin_cond.sv
module irq_pin_cond #(
   parameter logic        ACT_LOW     = 1'b0,
   parameter logic        DEBOUNCE    = 1'b0,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned DB_CYCLES   = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic lvl_o
);
   logic sync_raw;
   logic active;

   // The synchronizer resets to the idle raw level, so reset yields an inactive level
   irq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(ACT_LOW)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  (pin_i),
      .q_o  (sync_raw)
   );

   assign active = sync_raw ^ ACT_LOW;

   generate
      if (DEBOUNCE) begin : g_filt
         irq_debounce #(.DB_CYCLES(DB_CYCLES)) u_db (
            .clk  (clk),
            .rst_n(rst_n),
            .lvl_i(active),
            .lvl_o(lvl_o)
         );
      end else begin : g_pass
         assign lvl_o = active;
      end
   endgenerate
endmodule

// File: rtl/irq_cond_mask.sv
module irq_cond_mask
   import irq_cond_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned DB_CYCLES   = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [PIN_N-1:0]    ext_pin_i,
   input  logic [PERIPH_N-1:0] periph_irq_i,
   input  logic [VEC_W-1:0]    en_mask_i,
   input  logic [VEC_W-1:0]    clr_i,
   output logic [VEC_W-1:0]    irq_pend_o,
   output logic                irq_req_o
);
   localparam logic [VEC_W-1:0] VALID = valid_mask();

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (DB_CYCLES < 2) begin : g_bad_db
         $error("DB_CYCLES must be at least 2");
      end
   endgenerate

   logic [PIN_N-1:0] pin_lvl;
   logic [VEC_W-1:0] src_lvl;
   logic [VEC_W-1:0] lvl_q;
   logic [VEC_W-1:0] rise;
   logic [VEC_W-1:0] pend_q;

   generate
      for (genvar p = 0; p < PIN_N; p++) begin : g_pin
         irq_pin_cond #(
            .ACT_LOW    (PIN_ACT_LOW[p]),
            .DEBOUNCE   (PIN_DEBOUNCE[p]),
            .SYNC_STAGES(SYNC_STAGES),
            .DB_CYCLES  (DB_CYCLES)
         ) u_cond (
            .clk  (clk),
            .rst_n(rst_n),
            .pin_i(ext_pin_i[p]),
            .lvl_o(pin_lvl[p])
         );
      end
   endgenerate

   always_comb begin
      src_lvl = '0;
      for (int i = 0; i < PIN_N; i++)    src_lvl[PIN_POS[i]]    = pin_lvl[i];
      for (int i = 0; i < PERIPH_N; i++) src_lvl[PERIPH_POS[i]] = periph_irq_i[i];
   end

   assign rise = src_lvl & ~lvl_q & VALID;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q  <= '0;
         pend_q <= '0;
      end else begin
         lvl_q  <= src_lvl;
         pend_q <= ((pend_q & ~clr_i) | rise) & VALID;
      end
   end

   assign irq_pend_o = pend_q & en_mask_i;
   assign irq_req_o  = |irq_pend_o;
endmodule

// File: rtl/irq_cond_chk.sv
module irq_cond_chk
   import irq_cond_pkg::*;
(
   input logic                clk,
   input logic                rst_n,
   input logic [PERIPH_N-1:0] periph_irq_i,
   input logic [VEC_W-1:0]    en_mask_i,
   input logic [VEC_W-1:0]    clr_i,
   input logic [VEC_W-1:0]    pend_q,
   input logic [VEC_W-1:0]    irq_pend_o,
   input logic                irq_req_o
);
   // R8
   reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q & 16'h8430) == '0);

   // R9
   mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_pend_o & ~en_mask_i) == '0);

   // R10
   req_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req_o |-> (en_mask_i != '0) && (pend_q != '0));

   generate
      for (genvar k = 0; k < PERIPH_N; k++) begin : g_src
         // R5
         periph_set_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pend_q[PERIPH_POS[k]]) |-> $past(periph_irq_i[k]));
         // R7
         periph_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(clr_i[PERIPH_POS[k]]) && !$past(periph_irq_i[k])) |-> !pend_q[PERIPH_POS[k]]);
      end
   endgenerate
endmodule

bind irq_cond_mask irq_cond_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .periph_irq_i(periph_irq_i),
   .en_mask_i   (en_mask_i),
   .clr_i       (clr_i),
   .pend_q      (pend_q),
   .irq_pend_o  (irq_pend_o),
   .irq_req_o   (irq_req_o)
);

// File: tb/tb_irq_cond_mask.sv
`timescale 1ns/1ps
module tb_irq_cond_mask;
   localparam int DB = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  ext_pin_i = 4'b1100;
   logic [7:0]  periph_irq_i = '0;
   logic [15:0] en_mask_i = 16'hFFFF;
   logic [15:0] clr_i = '0;
   logic [15:0] irq_pend_o;
   logic        irq_req_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #5 clk = ~clk;

   irq_cond_mask #(.SYNC_STAGES(2), .DB_CYCLES(DB)) dut (
      .clk(clk), .rst_n(rst_n), .ext_pin_i(ext_pin_i), .periph_irq_i(periph_irq_i),
      .en_mask_i(en_mask_i), .clr_i(clr_i), .irq_pend_o(irq_pend_o), .irq_req_o(irq_req_o)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clear_all();
      clr_i = 16'hFFFF;
      tick(1);
      clr_i = '0;
   endtask

   task automatic t_reset();
      chk("R11 pend", irq_pend_o, 16'h0000);
      chk("R11 req", {15'b0, irq_req_o}, 16'h0000);
   endtask

   task automatic t_pin1();
      ext_pin_i[1] = 1'b1;
      tick(2);
      chk("R1 not yet after 2 edges", irq_pend_o, 16'h0000);
      tick(1);
      chk("R2 pin1 sets bit12", irq_pend_o, 16'h1000);
      tick(4);
      clear_all();
      tick(3);
      chk("R6 held level no re-set", irq_pend_o, 16'h0000);
      ext_pin_i[1] = 1'b0;
      tick(4);
   endtask

   task automatic t_active_low();
      ext_pin_i[2] = 1'b0;
      tick(3);
      chk("R3 pin2 fall sets bit13", irq_pend_o, 16'h2000);
      ext_pin_i[3] = 1'b0;
      tick(3);
      chk("R3 pin3 fall sets bit14", irq_pend_o, 16'h6000);
      clear_all();
      ext_pin_i[3:2] = 2'b11;
      tick(6);
      chk("R3 rising raw ignored", irq_pend_o, 16'h0000);
   endtask

   task automatic t_debounce();
      ext_pin_i[0] = 1'b1;
      tick(DB - 1);
      ext_pin_i[0] = 1'b0;
      tick(10);
      chk("R4 short pulse filtered", irq_pend_o, 16'h0000);
      ext_pin_i[0] = 1'b1;
      tick(6);
      chk("R4 not before filter settles", irq_pend_o, 16'h0000);
      tick(1);
      chk("R4 pin0 sets bit1", irq_pend_o, 16'h0002);
      ext_pin_i[0] = 1'b0;
      tick(8);
      clear_all();
   endtask

   task automatic t_periph();
      int pos [8] = '{0, 2, 3, 6, 7, 8, 9, 11};
      for (int k = 0; k < 8; k++) begin
         periph_irq_i[k] = 1'b1;
         tick(1);
         chk($sformatf("R5 periph %0d", k), irq_pend_o, 16'(1) << pos[k]);
         periph_irq_i[k] = 1'b0;
         clear_all();
      end
   endtask

   task automatic t_w1c();
      periph_irq_i = 8'h11;
      tick(1);
      periph_irq_i = '0;
      clr_i = 16'h0001;
      tick(1);
      clr_i = '0;
      chk("R7 clear only bit0", irq_pend_o, 16'h0080);
      clr_i = 16'h0001;
      periph_irq_i[0] = 1'b1;
      tick(1);
      clr_i = '0;
      periph_irq_i[0] = 1'b0;
      chk("R7 set wins over clear", irq_pend_o, 16'h0081);
      clear_all();
   endtask

   task automatic t_reserved();
      periph_irq_i = 8'hFF;
      ext_pin_i = 4'b0011;
      tick(10);
      chk("R8 all sources, reserved zero", irq_pend_o, 16'h7BCF);
      clr_i = 16'hFFFF;
      tick(1);
      chk("R8 clear leaves reserved zero", irq_pend_o & 16'h8430, 16'h0000);
      clr_i = '0;
      periph_irq_i = '0;
      ext_pin_i = 4'b1100;
      tick(10);
      clear_all();
   endtask

   task automatic t_mask();
      periph_irq_i = 8'h15;
      tick(1);
      periph_irq_i = '0;
      en_mask_i = 16'h0081;
      #1;
      chk("R9 mask 0x0081", irq_pend_o, 16'h0081);
      chk("R10 req with enabled bit", {15'b0, irq_req_o}, 16'h0001);
      en_mask_i = 16'h0002;
      #1;
      chk("R9 nothing enabled pending", irq_pend_o, 16'h0000);
      chk("R10 req low", {15'b0, irq_req_o}, 16'h0000);
      en_mask_i = 16'hFFFF;
      #1;
      chk("R9 latched while masked", irq_pend_o, 16'h0089);
      clear_all();
   endtask

   initial begin
      tick(3);
      t_reset();
      rst_n = 1'b1;
      tick(4);
      t_reset();
      t_pin1();
      t_active_low();
      t_debounce();
      t_periph();
      t_w1c();
      t_reserved();
      t_mask();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         done = 1;
         checks++;
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule